// File: doc/BRIEF.md
# Go-Back-N Hybrid ARQ Link Controller

This block moves 64-bit flits across a pipelined on-chip link and controls both ends of it. On the sending side, a flit accepted over a valid/ready handshake is written into a small retransmission store. On the same clock edge it is captured, encoded into a 73-bit codeword, by the encoder stage. Nine check bits let the receiver correct any one wrong wire. The same check bits let it detect two wrong wires, or a run of two to four neighbouring wires that are all wrong. The wires are modelled as a chain of registers of fixed length. A test-only mask input flips chosen wires of the codeword as it enters that chain.

On the receiving side, a registered decoder fixes single-wire faults in place and delivers the flit. When it finds an error it cannot fix, it withholds the flit and returns a negative acknowledgement. Good flits are acknowledged through a return path of fixed length. Every flit carries a small sequence tag that travels beside the codeword. The receiver uses the tag to drop flits that were already in flight behind a rejected one. On a negative acknowledgement, the sender rewinds to the oldest unacknowledged flit and sends everything from there again, in order.

The window depth, the length of the link and the length of the acknowledgement path are all parameters. The sender can accept one flit every cycle when the window is at least the round trip, which is link stages + acknowledgement stages + 2.

Top module: `harq_link_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: A flit that meets no injected error appears on `out_data` unchanged, with `out_valid` high, exactly LINK_STAGES+1 rising edges after the edge that accepted it.
- R3: Bit i of `link_err` (i = 0..72) inverts codeword wire i of the flit accepted on the previous edge. Any one inverted wire is corrected with no resend: the flit is delivered with the R2 latency and the original data.
- R4: Two inverted wires, or 2 to 4 inverted wires with consecutive indices, are never delivered as data. The receiver rejects the flit and the sender resends it. The correct flit then appears 2*LINK_STAGES+ACK_STAGES+4 edges after its first acceptance, when nothing else is outstanding.
- R5: Under any mix of the faults in R3 and R4, the flits at the output are exactly the accepted flits, in acceptance order, with none duplicated and none missing.
- R6: No more than WIN flits are ever unacknowledged. `in_ready` is 0 while the window is full, while a rejection is arriving, and while a resend is in progress. In particular it is 0 in the cycle that is LINK_STAGES+ACK_STAGES+1 edges after a rejected flit was accepted.
- R7: With no injected faults and WIN at least equal to the round trip, `in_ready` stays 1 under continuous input.
- R8: Flits that arrive behind a rejected one are dropped by the receiver until the resent flit arrives, and they are delivered later from the resend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sender offers a flit |
| in_ready | output | 1 | Controller accepts the offered flit on this edge |
| in_data | input | 64 | Flit payload |
| link_err | input | 73 | Test-only wire inversion mask applied on the link entry |
| out_valid | output | 1 | A delivered flit is on `out_data` this cycle |
| out_data | output | 64 | Delivered (corrected) payload |

## Verification
A clean or singly-corrupted flit is due LINK_STAGES+1 edges after the edge that accepted it. A rejected flit reappears 2*LINK_STAGES+ACK_STAGES+4 edges after it was accepted. The ready drop caused by the rejection is due at LINK_STAGES+ACK_STAGES+1 edges. The bench records the edge number at which each flit is accepted. For directed flits it stores the latency expected for that flit, and the output monitor compares the edge count at each delivery with that latency. All sampling and driving happen on the falling edge, so each comparison falls in the one cycle where the result must already be visible. In the random phase, timing is left free and only order and content are scored.

// File: rtl/harq_pkg.sv
// Shared constants, code layout and decode status for the ARQ link.
// Code layout: wire i belongs to lane (i mod 4) and block (i div 4); its
// parity-check column is {block id, one-hot lane}. Consecutive wires lie in
// different lanes, so a run of 2..4 faults sets several lane bits of the
// syndrome, while a single fault sets exactly one.
package harq_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 9;
    localparam int CW_W   = DATA_W + CHK_W;
    localparam int LANE_W = 4;
    localparam int GRP_W  = CHK_W - LANE_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } dec_st_e;

    // Block identifier for each group of four wires (all distinct, non-zero).
    function automatic logic [GRP_W-1:0] grp_of(input int blk);
        case (blk)
            0:  return 5'd30;
            1:  return 5'd1;
            2:  return 5'd2;
            3:  return 5'd4;
            4:  return 5'd8;
            5:  return 5'd16;
            6:  return 5'd3;
            7:  return 5'd5;
            8:  return 5'd6;
            9:  return 5'd7;
            10: return 5'd9;
            11: return 5'd10;
            12: return 5'd11;
            13: return 5'd12;
            14: return 5'd13;
            15: return 5'd14;
            16: return 5'd15;
            17: return 5'd17;
            default: return 5'd18;
        endcase
    endfunction

    // Parity-check column of wire i.
    function automatic logic [CHK_W-1:0] col_of(input int i);
        logic [LANE_W-1:0] lane;
        lane = '0;
        lane[i % LANE_W] = 1'b1;
        return {grp_of(i / LANE_W), lane};
    endfunction

    // Check wires: 0..3 (block 30) and lane-0 wires of blocks 1..5.
    function automatic logic is_chk(input int i);
        return (i < LANE_W) || ((i % LANE_W == 0) && (i <= 5 * LANE_W));
    endfunction

endpackage

// File: rtl/harq_enc.sv
// Encoder stage: maps a 64-bit flit to a 73-bit codeword and registers it
// together with its sequence tag. Assumes the package code layout; the check
// bits are solved in closed form so the full syndrome of every codeword is 0.
module harq_enc
    import harq_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_vld,
    input  logic [DATA_W-1:0] src_data,
    input  logic [TAG_W-1:0]  src_tag,
    output logic              enc_vld,
    output logic [CW_W-1:0]   enc_cw,
    output logic [TAG_W-1:0]  enc_tag
);

    logic [CW_W-1:0]   cw_c;
    logic [CHK_W-1:0]  syn_d;
    logic [GRP_W-1:0]  hi_fix;
    logic [LANE_W-1:0] lo_fix;

    // Place data on the data wires, then solve the nine check wires.
    always_comb begin
        int d;
        d     = 0;
        cw_c  = '0;
        syn_d = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (!is_chk(i)) begin
                cw_c[i] = src_data[d];
                d++;
            end
        end
        for (int i = 0; i < CW_W; i++) begin
            if (!is_chk(i)) syn_d ^= col_of(i) & {CHK_W{cw_c[i]}};
        end
        lo_fix = {syn_d[LANE_W-1:1], syn_d[0] ^ (^syn_d[CHK_W-1:LANE_W])};
        hi_fix = syn_d[CHK_W-1:LANE_W] ^ ((^lo_fix) ? 5'd30 : 5'd0);
        cw_c[LANE_W-1:0] = lo_fix;
        for (int k = 0; k < GRP_W; k++) cw_c[LANE_W * (k + 1)] = hi_fix[k];
    end

    // Encoder pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) enc_vld <= 1'b0;
        else        enc_vld <= src_vld;
        enc_cw  <= cw_c;
        enc_tag <= src_tag;
    end

endmodule

// File: rtl/harq_dec.sv
// Decoder stage: computes the syndrome of a received codeword, corrects a
// single faulty wire, flags anything else non-zero as uncorrectable, and
// registers data, tag and status. Assumes the package code layout.
module harq_dec
    import harq_pkg::*;
#(
    parameter int TAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_vld,
    input  logic [CW_W-1:0]   lk_cw,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              dec_vld,
    output logic [DATA_W-1:0] dec_data,
    output logic [TAG_W-1:0]  dec_tag,
    output dec_st_e           dec_st
);

    logic [CHK_W-1:0]  syn;
    logic [CW_W-1:0]   hit;
    logic [CW_W-1:0]   fixed_cw;
    logic [DATA_W-1:0] data_c;
    dec_st_e           st_c;

    // Syndrome, single-wire match, correction and data extraction.
    always_comb begin
        int d;
        d   = 0;
        syn = '0;
        for (int i = 0; i < CW_W; i++) syn ^= col_of(i) & {CHK_W{lk_cw[i]}};
        for (int i = 0; i < CW_W; i++) hit[i] = (syn == col_of(i));
        fixed_cw = lk_cw ^ hit;
        data_c   = '0;
        for (int i = 0; i < CW_W; i++) begin
            if (!is_chk(i)) begin
                data_c[d] = fixed_cw[i];
                d++;
            end
        end
        if (syn == '0)  st_c = ST_CLEAN;
        else if (|hit)  st_c = ST_FIXED;
        else            st_c = ST_BAD;
    end

    // Decoder pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) dec_vld <= 1'b0;
        else        dec_vld <= lk_vld;
        dec_data <= data_c;
        dec_tag  <= lk_tag;
        dec_st   <= st_c;
    end

endmodule

// File: rtl/harq_tx.sv
// Sender control: assigns sequence tags, keeps the last WIN unacknowledged
// flits, frees them on in-order acknowledgements and rewinds on a rejection.
// Assumes WIN is a power of two and that acknowledgements arrive in tag order.
module harq_tx
    import harq_pkg::*;
#(
    parameter int WIN   = 4,
    parameter int TAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              ack_vld,
    input  logic              ack_nack,
    input  logic [TAG_W-1:0]  ack_tag,
    output logic              snd_vld,
    output logic [DATA_W-1:0] snd_data,
    output logic [TAG_W-1:0]  snd_tag
);

    localparam int IDX_W = $clog2(WIN);

    logic [DATA_W-1:0] store [WIN];
    logic [TAG_W-1:0]  base, nxt, sptr;
    logic [TAG_W-1:0]  outstanding;
    logic              ack_ok, nack_in, resend, accept;

    // Window occupancy, handshake and send selection.
    always_comb begin
        outstanding = nxt - base;
        ack_ok      = ack_vld && !ack_nack;
        nack_in     = ack_vld && ack_nack;
        resend      = (sptr != nxt);
        in_ready    = !resend && !nack_in &&
                      ((outstanding - TAG_W'(ack_ok)) < TAG_W'(WIN));
        accept      = in_valid && in_ready;
        snd_vld     = (resend && !nack_in) || accept;
        snd_data    = resend ? store[sptr[IDX_W-1:0]] : in_data;
        snd_tag     = resend ? sptr : nxt;
    end

    // Sequence pointers: new flits, resends, releases and rewinds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base <= '0;
            nxt  <= '0;
            sptr <= '0;
        end else begin
            if (accept) nxt <= nxt + 1'b1;
            if (ack_ok) base <= base + 1'b1;
            if (nack_in)                    sptr <= ack_tag;
            else if (accept || resend)      sptr <= sptr + 1'b1;
        end
    end

    // Retransmission store, written on the accepting edge (no reset needed).
    always_ff @(posedge clk) begin
        if (accept) store[nxt[IDX_W-1:0]] <= in_data;
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= TAG_W'(WIN));

    assert_ack_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> ack_tag == base);

    assert_accept_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (sptr == nxt) && !ack_nack);

    assert_resend_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sptr != nxt) |-> (TAG_W'(sptr - base) < outstanding));

endmodule

// File: rtl/harq_rx.sv
// Receiver control: delivers flits whose tag is the expected one and whose
// status is not uncorrectable, answers each expected flit with an accept or a
// reject, and drops every flit with another tag. Responses travel back
// through ACK_STAGES registers (ACK_STAGES >= 1).
module harq_rx
    import harq_pkg::*;
#(
    parameter int TAG_W      = 3,
    parameter int ACK_STAGES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_vld,
    input  logic [DATA_W-1:0] dec_data,
    input  logic [TAG_W-1:0]  dec_tag,
    input  dec_st_e           dec_st,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ack_vld,
    output logic              ack_nack,
    output logic [TAG_W-1:0]  ack_tag
);

    logic [TAG_W-1:0]                  exp_tag;
    logic                              in_seq;
    logic [ACK_STAGES-1:0]             a_vld, a_nack;
    logic [ACK_STAGES-1:0][TAG_W-1:0]  a_tag;

    // Sequence match and delivery.
    always_comb begin
        in_seq    = dec_vld && (dec_tag == exp_tag);
        out_valid = in_seq && (dec_st != ST_BAD);
        out_data  = dec_data;
    end

    // Expected tag advances on each delivered flit.
    always_ff @(posedge clk) begin
        if (!rst_n)         exp_tag <= '0;
        else if (out_valid) exp_tag <= exp_tag + 1'b1;
    end

    // Response return path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_vld <= '0;
        end else begin
            a_vld[0] <= in_seq;
            for (int s = 1; s < ACK_STAGES; s++) a_vld[s] <= a_vld[s-1];
        end
        a_nack[0] <= (dec_st == ST_BAD);
        a_tag[0]  <= dec_tag;
        for (int s = 1; s < ACK_STAGES; s++) begin
            a_nack[s] <= a_nack[s-1];
            a_tag[s]  <= a_tag[s-1];
        end
    end

    assign ack_vld  = a_vld[ACK_STAGES-1];
    assign ack_nack = a_nack[ACK_STAGES-1];
    assign ack_tag  = a_tag[ACK_STAGES-1];

    assert_drop_stale_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_vld && dec_tag != exp_tag) |=> exp_tag == $past(exp_tag));

endmodule

// File: rtl/harq_link_ctrl.sv
// Top level: sender control, encoder stage, a LINK_STAGES register chain
// standing in for the wires (with a test-only inversion mask at its entry),
// decoder stage and receiver control with its response path.
// Assumes WIN is a power of two; full rate needs WIN >= LINK_STAGES+ACK_STAGES+2.
module harq_link_ctrl
    import harq_pkg::*;
#(
    parameter int WIN         = 4,
    parameter int LINK_STAGES = 1,
    parameter int ACK_STAGES  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CW_W-1:0]   link_err,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    localparam int TAG_W = $clog2(WIN) + 1;

    logic              snd_vld;
    logic [DATA_W-1:0] snd_data;
    logic [TAG_W-1:0]  snd_tag;
    logic              enc_vld;
    logic [CW_W-1:0]   enc_cw;
    logic [TAG_W-1:0]  enc_tag;
    logic [LINK_STAGES-1:0]            lk_vld;
    logic [LINK_STAGES-1:0][CW_W-1:0]  lk_cw;
    logic [LINK_STAGES-1:0][TAG_W-1:0] lk_tag;
    logic              dec_vld;
    logic [DATA_W-1:0] dec_data;
    logic [TAG_W-1:0]  dec_tag;
    dec_st_e           dec_st;
    logic              ack_vld, ack_nack;
    logic [TAG_W-1:0]  ack_tag;

    harq_tx #(.WIN(WIN), .TAG_W(TAG_W)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .ack_vld(ack_vld), .ack_nack(ack_nack), .ack_tag(ack_tag),
        .snd_vld(snd_vld), .snd_data(snd_data), .snd_tag(snd_tag)
    );

    harq_enc #(.TAG_W(TAG_W)) u_enc (
        .clk(clk), .rst_n(rst_n),
        .src_vld(snd_vld), .src_data(snd_data), .src_tag(snd_tag),
        .enc_vld(enc_vld), .enc_cw(enc_cw), .enc_tag(enc_tag)
    );

    // Wire model: fixed-length register chain, fault mask applied at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) lk_vld <= '0;
        else begin
            lk_vld[0] <= enc_vld;
            for (int s = 1; s < LINK_STAGES; s++) lk_vld[s] <= lk_vld[s-1];
        end
        lk_cw[0]  <= enc_cw ^ link_err;
        lk_tag[0] <= enc_tag;
        for (int s = 1; s < LINK_STAGES; s++) begin
            lk_cw[s]  <= lk_cw[s-1];
            lk_tag[s] <= lk_tag[s-1];
        end
    end

    harq_dec #(.TAG_W(TAG_W)) u_dec (
        .clk(clk), .rst_n(rst_n),
        .lk_vld(lk_vld[LINK_STAGES-1]), .lk_cw(lk_cw[LINK_STAGES-1]),
        .lk_tag(lk_tag[LINK_STAGES-1]),
        .dec_vld(dec_vld), .dec_data(dec_data), .dec_tag(dec_tag), .dec_st(dec_st)
    );

    harq_rx #(.TAG_W(TAG_W), .ACK_STAGES(ACK_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .dec_vld(dec_vld), .dec_data(dec_data), .dec_tag(dec_tag), .dec_st(dec_st),
        .out_valid(out_valid), .out_data(out_data),
        .ack_vld(ack_vld), .ack_nack(ack_nack), .ack_tag(ack_tag)
    );

    assert_clean_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_vld && link_err == '0) |=> lk_cw[0] == $past(enc_cw));

endmodule

// File: tb/tb_harq_link_ctrl.sv
module tb_harq_link_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WIN = 4, LS = 1, AS = 1, CW = 73;
    localparam int LAT_OK = LS + 1;
    localparam int LAT_RS = 2 * LS + AS + 4;
    localparam int WD_LIMIT = 100000;

    logic          clk, rst_n, in_valid, in_ready, out_valid;
    logic [63:0]   in_data, out_data;
    logic [CW-1:0] link_err;

    harq_link_ctrl #(.WIN(WIN), .LINK_STAGES(LS), .ACK_STAGES(AS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .link_err(link_err),
        .out_valid(out_valid), .out_data(out_data)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    int wr = 0, rd = 0;
    logic [63:0] exp_q [256];
    int acc_q [256];
    int lat_q [256];
    logic [CW-1:0] pend = '0;
    logic done = 1'b0;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Scoreboard: order, content and (for directed flits) latency. R2 R5
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (rd >= wr) begin
                chk(1'b0, "R5", "extra delivery", longint'(out_data), 0);
            end else begin
                chk(out_data == exp_q[rd % 256], "R5", "delivered data",
                    longint'(out_data), longint'(exp_q[rd % 256]));
                if (lat_q[rd % 256] != 0)
                    chk(cyc - acc_q[rd % 256] == lat_q[rd % 256], "R2", "delivery latency",
                        cyc - acc_q[rd % 256], lat_q[rd % 256]);
                rd++;
            end
        end
    end

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        if (!done && cyc == WD_LIMIT) begin
            chk(1'b0, "R5", "watchdog expired", cyc, WD_LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // One cycle of stimulus; mask is applied only if this offer is accepted.
    task automatic step(input bit v, input logic [63:0] d, input logic [CW-1:0] m,
                        input int lat);
        @(negedge clk);
        link_err = pend;
        pend     = '0;
        in_valid = v;
        in_data  = d;
        #1;
        if (in_valid && in_ready) begin
            exp_q[wr % 256] = d;
            acc_q[wr % 256] = cyc + 1;
            lat_q[wr % 256] = lat;
            wr++;
            pend = m;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, 0);
    endtask

    task automatic drain();
        int k;
        k = 0;
        while (rd != wr && k < 200) begin
            step(1'b0, '0, '0, 0);
            k++;
        end
        idle(4);
    endtask

    function automatic logic [CW-1:0] rand_mask();
        logic [CW-1:0] m;
        int a, b, len;
        m = '0;
        case ($urandom % 3)
            0: begin
                m[$urandom % CW] = 1'b1;
            end
            1: begin
                a = $urandom % CW;
                b = (a + 1 + ($urandom % (CW - 1))) % CW;
                m[a] = 1'b1;
                m[b] = 1'b1;
            end
            default: begin
                len = 2 + ($urandom % 3);
                a   = $urandom % (CW - len + 1);
                for (int k = 0; k < len; k++) m[a + k] = 1'b1;
            end
        endcase
        return m;
    endfunction

    initial begin
        int acc, cnt, start;
        logic [CW-1:0] m;
        bit all_ready;
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; link_err = '0;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready in reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        // R2: clean single flits
        step(1'b1, 64'hDEAD_BEEF_0123_4567, '0, LAT_OK);
        idle(5);
        step(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, '0, LAT_OK);
        idle(5);

        // R3: every single wire, corrected with no resend
        for (int b = 0; b < CW; b++) begin
            m = '0;
            m[b] = 1'b1;
            step(1'b1, {$urandom, $urandom}, m, LAT_OK);
            idle(3);
        end
        drain();

        // R4 R6: double fault, then ready low while the rejection arrives
        m = '0; m[5] = 1'b1; m[9] = 1'b1;
        step(1'b1, 64'h0BAD_F00D_CAFE_1234, m, LAT_RS);
        acc = acc_q[(wr - 1) % 256];
        while (cyc < acc + LS + AS + 1) step(1'b0, '0, '0, 0);
        chk(in_ready == 1'b0, "R6", "ready during rejection", in_ready, 0);
        drain();

        // R4: adjacent runs of 2, 3 and 4 wires at several positions
        for (int len = 2; len <= 4; len++) begin
            for (int p = 0; p < 3; p++) begin
                start = (p == 0) ? 0 : (p == 1) ? 33 : CW - len;
                m = '0;
                for (int k = 0; k < len; k++) m[start + k] = 1'b1;
                step(1'b1, {$urandom, $urandom}, m, LAT_RS);
                drain();
            end
        end

        // R8: back-to-back stream, third flit rejected, later ones dropped then resent
        cnt = 0;
        while (cnt < 8) begin
            m = '0;
            if (cnt == 2) begin m[40] = 1'b1; m[41] = 1'b1; m[42] = 1'b1; end
            step(1'b1, 64'hA5A5_0000_0000_0000 | 64'(cnt), m, 0);
            cnt = wr - rd > 0 ? cnt : cnt;
            cnt = (in_valid && in_ready) ? cnt + 1 : cnt;
        end
        drain();
        chk(rd == wr, "R8", "stream delivered once each", rd, wr);

        // R7: continuous input with no faults keeps ready high
        all_ready = 1'b1;
        for (int k = 0; k < 40; k++) begin
            step(1'b1, {$urandom, $urandom}, '0, LAT_OK);
            if (!in_ready) all_ready = 1'b0;
        end
        chk(all_ready, "R7", "ready held under full rate", all_ready, 1);
        drain();

        // R5: random traffic with mixed correctable and uncorrectable faults
        for (int n = 0; n < 3000; n++) begin
            m = (($urandom % 6) == 0) ? rand_mask() : '0;
            step((($urandom % 10) < 7), {$urandom, $urandom}, m, 0);
        end
        drain();
        chk(rd == wr, "R5", "all accepted flits delivered", rd, wr);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule